// File: doc/BRIEF.md
# Interleaved Multi-Bank Read Scheduler

This block connects one read requester to a memory built from several banks that each become unavailable for a short time after every access. Each request carries an address. The low address bits pick the target bank, so consecutive addresses fall on consecutive banks. A request that targets an idle bank is issued in the cycle it is presented. Requests to different banks therefore issue one per cycle, and their read data comes back one word per cycle with no gaps. A request that targets a bank still recovering from its previous access is held off with a low `req_ready` until that bank is free again.

A two-bit mode input selects one of three arrangements. In the first, the full set of banks is used. In the second, half of the banks are used. In the third, interleaving is off and every request goes to a single bank, so accesses run strictly one after another with a recovery gap between them. Each bank is modelled as a read-only behavioural store: it registers a data word on issue and then counts down a fixed recovery period. Because every access has the same one-cycle latency, responses always return in request order.

Top module: `bis_sched`

## Requirements
- R1: The bank index comes from `req_addr`. With mode 2'b10 it is `req_addr[1:0]` (four banks). With mode 2'b01 it is `req_addr[0]` (two banks). With mode 2'b00 or 2'b11, every address maps to bank 0 (interleave off).
- R2: When successive requests target banks that are not busy, one request is accepted in every clock cycle. Four requests to four distinct banks are accepted in four consecutive cycles, and their data is delivered within five cycles.
- R3: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. `rsp_valid` is then high in the next cycle, and `rsp_data` equals the request's address, zero-extended, XOR 32'h5A5A0F0F.
- R4: After a bank is issued a request, it stays busy for two cycles: one data cycle and one recovery cycle. A later request to the same bank is accepted no earlier than three cycles after the previous one.
- R5: `req_ready` is low, combinationally from `req_addr` and `mode`, while the bank addressed by the current request is busy. It is high otherwise. No request is ever issued to a busy bank.
- R6: With interleave off (mode 2'b00 or 2'b11), requests are accepted at most once every three cycles. Four requests occupy twelve cycles, counting the final recovery.
- R7: `rsp_valid` pulses exactly once for each accepted request and never otherwise. Responses come back in the order the requests were accepted.
- R8: A synchronous active-high `rst` clears every bank's busy state and any pending response. In the cycle after reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00/11 interleave off, 01 two-bank, 10 four-bank |
| req_valid | input | 1 | Request present |
| req_addr | input | AW (16) | Request address |
| req_ready | output | 1 | Addressed bank can take the request this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW (32) | Read data |

## Verification
The assertions assume that `mode` does not change while any bank is still busy. A switch mid-flight could redirect a held request to a bank whose busy state comes from the other arrangement. They also assume that a presented request is kept stable until it is accepted. The directed tasks change `mode` only after several idle cycles. They hold `req_valid` and `req_addr` steady until the handshake completes, and they drive every input on the falling edge.

// File: rtl/bis_pkg.sv
package bis_pkg;

    typedef enum logic [1:0] {
        ILV_OFF  = 2'b00,
        ILV_HALF = 2'b01,
        ILV_FULL = 2'b10,
        ILV_OFF2 = 2'b11
    } ilv_mode_e;

    // Cycles a bank stays unavailable after an issue: one data cycle and one recovery cycle.
    localparam int unsigned RECOVER_CYC = 2;

endpackage

// File: rtl/bis_bank_map.sv
module bis_bank_map
    import bis_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned NB = 4,
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  ilv_mode_e          mode_i,
    input  logic [AW-1:0]      addr_i,
    output logic [BW-1:0]      bank_o
);

    localparam logic [BW-1:0] FULL_MASK = BW'(NB - 1);
    localparam logic [BW-1:0] HALF_MASK = BW'((NB / 2) - 1);

    always_comb begin
        unique case (mode_i)
            ILV_FULL: bank_o = addr_i[BW-1:0] & FULL_MASK;
            ILV_HALF: bank_o = addr_i[BW-1:0] & HALF_MASK;
            default:  bank_o = '0;
        endcase
    end

endmodule

// File: rtl/bis_bank.sv
module bis_bank
    import bis_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned DW  = 32,
    parameter logic [DW-1:0] KEY = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           issue_i,
    input  logic [AW-1:0]  addr_i,
    output logic           busy_o,
    output logic [DW-1:0]  data_o
);

    localparam int unsigned CW = $clog2(RECOVER_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (issue_i) begin
            s_d.cnt  = CW'(RECOVER_CYC);
            s_d.data = KEY ^ DW'(addr_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.cnt != '0);
    assign data_o = s_q.data;

    // R5
    no_issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> !busy_o);

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> busy_o ##1 busy_o ##1 !busy_o);

endmodule

// File: rtl/bis_sched.sv
module bis_sched
    import bis_pkg::*;
#(
    parameter int unsigned   AW  = 16,
    parameter int unsigned   DW  = 32,
    parameter int unsigned   NB  = 4,
    parameter logic [DW-1:0] KEY = DW'(32'h5A5A_0F0F)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     mode,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    output logic           req_ready,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data
);

    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic          rsp_valid;
        logic [BW-1:0] sel;
    } top_st_t;

    top_st_t s_d, s_q;

    ilv_mode_e     mode_e;
    logic [BW-1:0] bank_sel;
    logic [NB-1:0] busy;
    logic [NB-1:0] issue;
    logic [DW-1:0] bank_data [NB];
    logic          accept;

    assign mode_e = ilv_mode_e'(mode);

    bis_bank_map #(.AW(AW), .NB(NB)) u_map (
        .mode_i (mode_e),
        .addr_i (req_addr),
        .bank_o (bank_sel)
    );

    assign req_ready = !busy[bank_sel];
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign issue[g] = accept && (bank_sel == BW'(g));

        bis_bank #(.AW(AW), .DW(DW), .KEY(KEY)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .issue_i (issue[g]),
            .addr_i  (req_addr),
            .busy_o  (busy[g]),
            .data_o  (bank_data[g])
        );
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = accept;
        if (accept) begin
            s_d.sel = bank_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_data  = bank_data[s_q.sel];

    // R3
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R7
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    // R3
    rsp_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_data == (KEY ^ DW'($past(req_addr)))));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && (busy == '0)));

endmodule

// File: tb/bis_sched_tb.sv
`timescale 1ns/1ps
module bis_sched_tb;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 32;
    localparam logic [31:0] KEY = 32'h5A5A_0F0F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b10;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bis_sched #(.AW(AW), .DW(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bank_of(input logic [1:0] m, input int a);
        if (m == 2'b10) return a % 4;
        if (m == 2'b01) return a % 2;
        return 0;
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Drive a sequence of addresses and compare accept/response cycles with a bank-occupancy model.
    task automatic run_seq(input string req, input int n, input int a0, input int a1,
                           input int a2, input int a3, output int last_cyc);
        int addrs [4];
        int acc_cyc [4];
        int rsp_cyc [4];
        logic [DW-1:0] rsp_dat [4];
        int free_t [4];
        int exp_t, prev, i, r, cyc;
        addrs = '{a0, a1, a2, a3};
        free_t = '{0, 0, 0, 0};
        i = 0; r = 0; cyc = 0;
        while ((r < n) && (cyc < 100)) begin
            @(negedge clk);
            if (rsp_valid) begin
                if (r < 4) begin
                    rsp_cyc[r] = cyc;
                    rsp_dat[r] = rsp_data;
                end
                r++;
            end
            if (i < n) begin
                req_valid = 1'b1;
                req_addr  = AW'(addrs[i]);
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (req_valid && req_ready) begin
                acc_cyc[i] = cyc;
                i++;
            end
            cyc++;
        end
        req_valid = 1'b0;
        chk(r == n, {req, " response count"}, r, n);
        prev = -1;
        last_cyc = 0;
        for (int k = 0; k < n; k++) begin
            int b;
            b = bank_of(mode, addrs[k]);
            exp_t = (prev + 1 > free_t[b]) ? prev + 1 : free_t[b];
            free_t[b] = exp_t + 3;
            prev = exp_t;
            chk(acc_cyc[k] == exp_t, {req, " accept cycle"}, acc_cyc[k], exp_t);
            chk(rsp_cyc[k] == acc_cyc[k] + 1, "R3 response latency", rsp_cyc[k], acc_cyc[k] + 1);
            chk(rsp_dat[k] == (KEY ^ DW'(addrs[k])), "R7 R3 ordered response data",
                rsp_dat[k], KEY ^ DW'(addrs[k]));
            last_cyc = rsp_cyc[k];
        end
        idle(4);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        #1;
        chk(rsp_valid == 1'b0, "R8 rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
        mode = 2'b10;
        req_addr = AW'(0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req_addr = AW'(4);
        #1;
        chk(rsp_valid == 1'b0, "R8 pending response cleared", rsp_valid, 0);
        chk(req_ready == 1'b1, "R8 busy cleared", req_ready, 1);
        idle(3);
    endtask

    task automatic t_four_bank();
        int last;
        mode = 2'b10;
        run_seq("R2 R1 four distinct banks", 4, 0, 1, 2, 3, last);
        chk(last == 4, "R2 four words in five cycles", last, 4);
        run_seq("R1 four-bank mixed", 4, 5, 9, 6, 7, last);
    endtask

    task automatic t_same_bank();
        int last;
        mode = 2'b10;
        run_seq("R4 same bank", 2, 4, 8, 0, 0, last);
        chk(last == 4, "R4 serialized last data", last, 4);
    endtask

    task automatic t_two_bank();
        int last;
        mode = 2'b01;
        run_seq("R1 two-bank", 4, 0, 1, 2, 3, last);
        chk(last == 5, "R1 two-bank last data", last, 5);
    endtask

    task automatic t_off(input logic [1:0] m);
        int last;
        mode = m;
        run_seq("R6 interleave off", 4, 0, 1, 2, 3, last);
        chk(last == 10, "R6 last data cycle", last, 10);
    endtask

    task automatic t_ready();
        mode = 2'b10;
        @(negedge clk);
        req_addr = AW'(2);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R5 idle bank ready", req_ready, 1);
        @(negedge clk);
        req_addr = AW'(6);
        #1;
        chk(req_ready == 1'b0, "R5 busy bank not ready (data)", req_ready, 0);
        req_addr = AW'(3);
        #1;
        chk(req_ready == 1'b1, "R5 other bank ready", req_ready, 1);
        req_valid = 1'b0;
        req_addr = AW'(6);
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R5 busy bank not ready (recovery)", req_ready, 0);
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R5 bank free again", req_ready, 1);
        idle(3);
    endtask

    initial begin
        #(8 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_four_bank();
        t_same_bank();
        t_two_bank();
        t_off(2'b00);
        t_off(2'b11);
        t_ready();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule